// File: doc/BRIEF.md
# Interrupt Flag Collector and Output Pin Driver

This block merges three event sources (watchdog expiry, supply-loss detect and calendar alarm match) into a single interrupt output. Each event sets a sticky flag. A flag drives the output only when the enable bit for that source is set. The host clears all flags by reading the flag register. The clear takes effect only when the read access completes with the write-enable strobe inactive.

A five-bit control register selects three things: the output polarity and drive style (active-high push-pull, or active-low open-drain emulated through an output-enable), and level or one-shot behaviour. In level mode the output stays asserted while an enabled flag is pending. In one-shot mode the output produces a pulse of `PULSE_CYC` cycles; at the default, 6554 cycles of a 32,768 Hz clock give about 200 ms, which is long enough to reset a host. While the part runs on backup power, only the alarm can assert the output, and only in open-drain active-low form.

The output sequencer has four states:
- `ST_IDLE`: output inactive.
- `ST_LEVEL`: output held.
- `ST_PULSE`: one-shot running.
- `ST_SPENT`: pulse finished, waiting for the pending flags to clear.

Its transitions are:
- `ST_IDLE`→`ST_LEVEL` when an enabled flag is pending and level mode is selected.
- `ST_IDLE`→`ST_PULSE` when an enabled flag is pending and pulse mode is selected.
- `ST_LEVEL`→`ST_IDLE` when nothing is pending, or when pulse mode is selected.
- `ST_PULSE`→`ST_SPENT` at the terminal count.
- `ST_SPENT`→`ST_IDLE` when nothing is pending, or when level mode is selected.

Top module: `irq_flag_driver`

## Requirements
- R1: After reset, the control register is 0, all flags are 0, and both `pin_oe` and `pin_val` are 0.
- R2: A strobe on `wdog_evt`, `pfail_evt` or `alarm_evt` sets `flags[0]`, `flags[1]` or `flags[2]` respectively at the next clock edge, whatever its enable bit holds.
- R3: All flags clear at the edge where `rd_active` falls, provided `wr_en_n` was high in the last cycle of the read. A read that ends with `wr_en_n` low leaves the flags unchanged. An event strobe in the clearing cycle still sets its flag.
- R4: A `ctl_wr` strobe loads `ctl_wdata` into the control register. The fields are: bit 0 watchdog enable, bit 1 supply-loss enable, bit 2 alarm enable, bit 3 active-high push-pull (1) or active-low open-drain (0), bit 4 pulse (1) or level (0) mode.
- R5: The output becomes active one cycle after a flag is visible together with its enable bit. A set flag whose enable is 0 never activates the output.
- R6: In level mode the output stays active until no enabled flag is pending. It goes inactive one cycle after the clearing read.
- R7: With bit 3 set and not in backup, `pin_oe` is 1 and `pin_val` equals the active state. With bit 3 clear, `pin_val` is 0 and `pin_oe` equals the active state.
- R8: In pulse mode the output is active for exactly `PULSE_CYC` consecutive cycles, starting one cycle after the qualifying flag is visible.
- R9: Events arriving during a pulse neither extend nor restart it. No new pulse starts until the pending enabled flags have been cleared.
- R10: While `in_backup` is 1, only the alarm flag can start an assertion, `pin_val` is 0, and the active state is shown on `pin_oe` alone, whatever bit 3 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (32,768 Hz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdog_evt | input | 1 | Watchdog expiry strobe |
| pfail_evt | input | 1 | Supply-loss detect strobe |
| alarm_evt | input | 1 | Alarm match strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control register write data |
| rd_active | input | 1 | High while the host reads the flag register |
| wr_en_n | input | 1 | Host write-enable level, active low |
| in_backup | input | 1 | Running from backup supply |
| flags | output | 3 | Sticky flags: alarm, supply loss, watchdog (MSB to LSB) |
| pin_val | output | 1 | Value driven onto the interrupt pin |
| pin_oe | output | 1 | Pin output enable (open-drain emulation) |

## Verification
The bench builds the block with `PULSE_CYC` = 12 instead of 6554. With that value a complete one-shot, an event landing in the middle of a pulse, and the wait in `ST_SPENT` all fit within a few dozen cycles. Several thousand random cycles can therefore pass through every state many times, combined with mode rewrites, reads that complete or are aborted, and backup entry and exit. Directed cases first pin down the exact pulse width and the backup restriction.

// File: rtl/irq_fd_pkg.sv
package irq_fd_pkg;
    localparam int NSRC      = 3;
    localparam int SRC_WDOG  = 0;
    localparam int SRC_PFAIL = 1;
    localparam int SRC_ALARM = 2;
    localparam int CTL_HIGH  = 3;
    localparam int CTL_PULSE = 4;
    localparam int CTL_W     = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEVEL = 2'd1,
        ST_PULSE = 2'd2,
        ST_SPENT = 2'd3
    } irq_state_e;
endpackage

// File: rtl/irq_fd_regs.sv
module irq_fd_regs
    import irq_fd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_evt,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             rd_active,
    input  logic             wr_en_n,
    output logic [NSRC-1:0]  flags_q,
    output logic [CTL_W-1:0] ctl_q
);
    logic rd_q;
    logic weh_q;
    logic clear_now;

    // a read is complete when the access ends and write-enable stayed inactive
    assign clear_now = rd_q & weh_q & ~rd_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            weh_q <= 1'b0;
            ctl_q <= '0;
        end else begin
            rd_q  <= rd_active;
            weh_q <= wr_en_n;
            if (ctl_wr) ctl_q <= ctl_wdata;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (src_evt[i]) flags_q[i] <= 1'b1;
            else if (clear_now)  flags_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_fd_timer.sv
module irq_fd_timer #(
    parameter int PULSE_CYC = 6554
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    assign done = run & (cnt == LAST);
endmodule

// File: rtl/irq_fd_pin.sv
module irq_fd_pin (
    input  logic active,
    input  logic act_high,
    input  logic in_backup,
    output logic pin_val,
    output logic pin_oe
);
    always_comb begin
        if (!in_backup && act_high) begin
            pin_oe  = 1'b1;
            pin_val = active;
        end else begin
            pin_oe  = active;
            pin_val = 1'b0;
        end
    end
endmodule

// File: rtl/irq_flag_driver.sv
module irq_flag_driver
    import irq_fd_pkg::*;
#(
    parameter int PULSE_CYC = 6554
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdog_evt,
    input  logic             pfail_evt,
    input  logic             alarm_evt,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             rd_active,
    input  logic             wr_en_n,
    input  logic             in_backup,
    output logic [NSRC-1:0]  flags,
    output logic             pin_val,
    output logic             pin_oe
);
    logic [NSRC-1:0]  flags_q;
    logic [CTL_W-1:0] ctl_q;
    logic [NSRC-1:0]  allow;
    logic             pending;
    logic             pulse_mode;
    logic             tmr_start;
    logic             tmr_run;
    logic             tmr_done;
    logic             irq_active;
    irq_state_e       state;
    irq_state_e       state_nx;

    irq_fd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   ({alarm_evt, pfail_evt, wdog_evt}),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .rd_active (rd_active),
        .wr_en_n   (wr_en_n),
        .flags_q   (flags_q),
        .ctl_q     (ctl_q)
    );

    // on backup power only the alarm source qualifies
    always_comb begin
        allow = '1;
        if (in_backup) begin
            allow = '0;
            allow[SRC_ALARM] = 1'b1;
        end
    end

    assign pending    = |(flags_q & ctl_q[NSRC-1:0] & allow);
    assign pulse_mode = ctl_q[CTL_PULSE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (pending) state_nx = pulse_mode ? ST_PULSE : ST_LEVEL;
            ST_LEVEL: if (!pending || pulse_mode) state_nx = ST_IDLE;
            ST_PULSE: if (tmr_done) state_nx = ST_SPENT;
            ST_SPENT: if (!pending || !pulse_mode) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_active = (state == ST_LEVEL) || (state == ST_PULSE);
        tmr_run    = (state == ST_PULSE);
        tmr_start  = (state == ST_IDLE) && (state_nx == ST_PULSE);
    end

    irq_fd_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    irq_fd_pin u_pin (
        .active    (irq_active),
        .act_high  (ctl_q[CTL_HIGH]),
        .in_backup (in_backup),
        .pin_val   (pin_val),
        .pin_oe    (pin_oe)
    );

    assign flags = flags_q;
endmodule

// File: rtl/irq_flag_driver_chk.sv
module irq_flag_driver_chk #(
    parameter int PULSE_CYC = 6554
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wdog_evt,
    input logic       pfail_evt,
    input logic       alarm_evt,
    input logic       rd_active,
    input logic       wr_en_n,
    input logic       in_backup,
    input logic [2:0] flags,
    input logic       pin_val,
    input logic       pin_oe,
    input logic [1:0] ctl_mode
);
    logic        primed;
    logic        act_seen;
    logic [31:0] run_cnt;

    assign act_seen = (in_backup || !ctl_mode[0]) ? pin_oe : pin_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed  <= 1'b0;
            run_cnt <= '0;
        end else begin
            primed <= 1'b1;
            if (act_seen && ctl_mode[1]) run_cnt <= run_cnt + 1;
            else                         run_cnt <= '0;
        end
    end

    a_r2_wdog_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_evt |=> flags[0]);
    a_r2_pfail_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pfail_evt |=> flags[1]);
    a_r2_alarm_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> flags[2]);
    a_r3_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(rd_active) && $past(wr_en_n) && !rd_active
         && !wdog_evt && !pfail_evt && !alarm_evt) |=> (flags == 3'b000));
    a_r7_push_pull_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_backup && ctl_mode[0]) |-> pin_oe);
    a_r7_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_mode[0]) |-> !pin_val);
    a_r10_backup_low: assert property (@(posedge clk) disable iff (!rst_n)
        in_backup |-> !pin_val);
    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mode[1] |-> (run_cnt <= 32'(PULSE_CYC)));
endmodule

bind irq_flag_driver irq_flag_driver_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdog_evt  (wdog_evt),
    .pfail_evt (pfail_evt),
    .alarm_evt (alarm_evt),
    .rd_active (rd_active),
    .wr_en_n   (wr_en_n),
    .in_backup (in_backup),
    .flags     (flags),
    .pin_val   (pin_val),
    .pin_oe    (pin_oe),
    .ctl_mode  (ctl_q[4:3])
);

// File: tb/test_irq_flag_driver.sv
module test_irq_flag_driver;
    localparam int CLK_PERIOD = 20;
    localparam int PULSE_CYC  = 12;
    localparam int M_IDLE = 0, M_LEVEL = 1, M_PULSE = 2, M_SPENT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdog_evt = 0, pfail_evt = 0, alarm_evt = 0;
    logic       ctl_wr = 0;
    logic [4:0] ctl_wdata = '0;
    logic       rd_active = 0, wr_en_n = 1, in_backup = 0;
    logic [2:0] flags;
    logic       pin_val, pin_oe;

    int vectors = 0;
    int misses  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_driver #(.PULSE_CYC(PULSE_CYC)) i_irq_flag_driver (
        .clk(clk), .rst_n(rst_n), .wdog_evt(wdog_evt), .pfail_evt(pfail_evt),
        .alarm_evt(alarm_evt), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rd_active(rd_active), .wr_en_n(wr_en_n), .in_backup(in_backup),
        .flags(flags), .pin_val(pin_val), .pin_oe(pin_oe)
    );

    // reference model built from the requirements
    logic [2:0] m_flags;
    logic [4:0] m_ctl;
    logic       m_rdq, m_wehq;
    int         m_mode, m_left;

    always @(posedge clk or negedge rst_n) begin : model
        logic [2:0] allow;
        logic pend, pm, clr;
        if (!rst_n) begin
            m_flags = '0; m_ctl = '0; m_rdq = 0; m_wehq = 0;
            m_mode = M_IDLE; m_left = 0;
        end else begin
            allow = in_backup ? 3'b100 : 3'b111;
            pend  = |(m_flags & m_ctl[2:0] & allow);
            pm    = m_ctl[4];
            clr   = m_rdq && m_wehq && !rd_active;
            case (m_mode)
                M_IDLE:  if (pend) begin
                             if (pm) begin m_mode = M_PULSE; m_left = PULSE_CYC; end
                             else m_mode = M_LEVEL;
                         end
                M_LEVEL: if (!pend || pm) m_mode = M_IDLE;
                M_PULSE: if (m_left == 1) m_mode = M_SPENT; else m_left--;
                default: if (!pend || !pm) m_mode = M_IDLE;
            endcase
            m_flags = (clr ? 3'b000 : m_flags) | {alarm_evt, pfail_evt, wdog_evt};
            if (ctl_wr) m_ctl = ctl_wdata;
            m_rdq  = rd_active;
            m_wehq = wr_en_n;
        end
    end

    function automatic logic [1:0] exp_pins(int mode, logic [4:0] ctl, logic bk);
        logic act;
        act = (mode == M_LEVEL) || (mode == M_PULSE);
        if (!bk && ctl[3]) return {1'b1, act};   // {oe, val}
        return {act, 1'b0};
    endfunction

    task automatic check(input string tag);
        logic [1:0] ep;
        ep = exp_pins(m_mode, m_ctl, in_backup);
        vectors++;
        if (flags !== m_flags || pin_oe !== ep[1] || pin_val !== ep[0]) begin
            misses++;
            $display("FAIL %s flags=%b oe=%b val=%b expected flags=%b oe=%b val=%b",
                     tag, flags, pin_oe, pin_val, m_flags, ep[1], ep[0]);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr_ctl(input logic [4:0] v, input string tag);
        ctl_wr = 1; ctl_wdata = v; cyc(tag); ctl_wr = 0;
    endtask

    task automatic do_read(input logic weh, input string tag);
        rd_active = 1; wr_en_n = weh; cyc(tag);
        rd_active = 0; cyc(tag); wr_en_n = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : main
        int act_cnt;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 explicit reset state
        vectors++;
        if (flags !== 3'b000 || pin_oe !== 0 || pin_val !== 0) begin
            misses++;
            $display("FAIL R1 flags=%b oe=%b val=%b expected 000 0 0", flags, pin_oe, pin_val);
        end
        check("R1");

        // R4 watchdog enable only, level, active low
        wr_ctl(5'b00001, "R4");
        pfail_evt = 1; cyc("R2"); pfail_evt = 0;   // flag set, not enabled
        cyc("R5");
        wdog_evt = 1; cyc("R2"); wdog_evt = 0;
        cyc("R5"); cyc("R7");                        // open-drain active
        do_read(1'b0, "R3");                         // aborted read keeps flags
        cyc("R6");
        do_read(1'b1, "R3");                         // completed read clears
        cyc("R6");
        // R3 event in clearing cycle survives
        rd_active = 1; cyc("R3"); rd_active = 0; alarm_evt = 1; cyc("R3"); alarm_evt = 0;
        do_read(1'b1, "R3");

        // R7 active-high push-pull on supply-loss
        wr_ctl(5'b01010, "R4");
        pfail_evt = 1; cyc("R7"); pfail_evt = 0;
        cyc("R7"); cyc("R7");
        do_read(1'b1, "R6"); cyc("R6");

        // R8 / R9 pulse mode, watchdog, active high
        wr_ctl(5'b11001, "R4");
        wdog_evt = 1; cyc("R8"); wdog_evt = 0;
        act_cnt = 0;
        for (int i = 0; i < PULSE_CYC + 6; i++) begin
            if (i == 4) wdog_evt = 1;                // R9 mid-pulse event
            cyc("R9");
            wdog_evt = 0;
            if (pin_val) act_cnt++;
        end
        vectors++;
        if (act_cnt != PULSE_CYC) begin
            misses++;
            $display("FAIL R8 pulse width=%0d expected %0d", act_cnt, PULSE_CYC);
        end
        wdog_evt = 1; cyc("R9"); wdog_evt = 0; cyc("R9"); cyc("R9");
        do_read(1'b1, "R9");
        wdog_evt = 1; cyc("R8"); wdog_evt = 0; cyc("R8"); cyc("R8");
        repeat (PULSE_CYC) cyc("R8");
        do_read(1'b1, "R8");

        // R10 backup: only alarm, open-drain only
        in_backup = 1;
        wr_ctl(5'b01111, "R10");
        wdog_evt = 1; pfail_evt = 1; cyc("R10"); wdog_evt = 0; pfail_evt = 0;
        cyc("R10"); cyc("R10");
        alarm_evt = 1; cyc("R10"); alarm_evt = 0;
        cyc("R10"); cyc("R10");
        do_read(1'b1, "R10"); cyc("R10");
        in_backup = 0; cyc("R10");

        // random phase
        for (int n = 0; n < 6000; n++) begin
            wdog_evt  = ($urandom % 20) == 0;
            pfail_evt = ($urandom % 24) == 0;
            alarm_evt = ($urandom % 28) == 0;
            ctl_wr    = ($urandom % 50) == 0;
            ctl_wdata = 5'($urandom);
            if (rd_active) rd_active = ($urandom % 3) != 0;
            else           rd_active = ($urandom % 18) == 0;
            wr_en_n   = ($urandom % 8) != 0;
            if (($urandom % 300) == 0) in_backup = ~in_backup;
            cyc("R5");
        end
        wdog_evt = 0; pfail_evt = 0; alarm_evt = 0; ctl_wr = 0; rd_active = 0;
        cyc("R6");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule